// File: doc/BRIEF.md
# Prescaled Up-Counting Time Base

This block is the time base of a general-purpose timer. An up-counter advances once every (divider + 1) input clocks. When it reaches a programmable limit it returns to zero on the next count and emits a one-cycle update pulse. A divider value written by software is held in a shadow register. It reaches the active divider only at an update event, so the count period never changes partway through a cycle.

Software accesses three registers through a single-cycle write port and a combinational read port. The registers are the counter, the divider and the limit. The count can also be restarted in two ways: a software strobe, or an external reset trigger. Either one clears the counter and the divider phase, loads the pending divider value and raises the update pulse. A global enable gates counting, and a limit of zero stops the counter.

Top module: `tbase_timer`

## Requirements
- R1: After reset the counter, divider (shadow and active) and limit are all zero, `upd` is low and every register reads back zero.
- R2: Register select codes are 0 = counter, 1 = divider, 2 = limit. A write with `wr_en` high stores `wr_data` into the selected register, and `rd_data` for the same code returns it. The divider reads back its shadow value.
- R3: With `en` high and a nonzero limit, the counter increments once every (active divider + 1) clocks.
- R4: On a count while the counter equals the limit, the counter becomes 0 and `upd` is high for exactly that one cycle.
- R5: A divider write changes only the shadow value. The count rate keeps the old divider until the next update event.
- R6: A `ug` pulse clears the counter and the divider phase, loads the shadow divider and raises `upd` on the next cycle. The first count after it takes a full (divider + 1) clocks.
- R7: A `trig` pulse has exactly the same effect as `ug`.
- R8: While the active limit is zero, the counter and the divider phase hold and no wrap update occurs.
- R9: A counter write takes effect on the next cycle and produces no update pulse. `ug`/`trig` take priority over a counter write, and a counter write takes priority over counting.
- R10: A counter value above the limit keeps counting up to all-ones, then rolls over to 0 without an update pulse.
- R11: With `en` low, the counter and divider phase hold, while `ug` and `trig` still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | CNT_W | Read data (combinational) |
| ug | input | 1 | Software update strobe |
| trig | input | 1 | External reset trigger |
| cnt_val | output | CNT_W | Live counter value |
| upd | output | 1 | One-cycle update pulse |

## Verification
The assertions assume that `ug`, `trig` and `wr_en` are synchronous to `clk` and free of X. They also assume that `wr_sel` carries one of the three defined codes whenever `wr_en` is high. The bench meets these assumptions by driving every input one time unit after the rising edge, from tasks only. Writes use only the codes 0 to 2. Divider writes never coincide with an update event, so the expected active divider stays unambiguous.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
   typedef enum logic [1:0] {
      SEL_CNT = 2'd0,
      SEL_DIV = 2'd1,
      SEL_LIM = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
   import tbase_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter bit LIM_PRELOAD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             load,
   output logic [CNT_W-1:0] div_shadow,
   output logic [CNT_W-1:0] div_act,
   output logic [CNT_W-1:0] lim_sw,
   output logic [CNT_W-1:0] lim_act
);
   logic wr_div, wr_lim;
   assign wr_div = wr_en && (wr_sel == SEL_DIV);
   assign wr_lim = wr_en && (wr_sel == SEL_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_shadow <= '0;
         div_act    <= '0;
      end else begin
         if (wr_div) div_shadow <= wr_data;
         if (load)   div_act    <= div_shadow;
      end
   end

   generate
      if (LIM_PRELOAD) begin : g_lim_shadow
         logic [CNT_W-1:0] lim_pre;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lim_pre <= '0;
               lim_act <= '0;
            end else begin
               if (wr_lim) lim_pre <= wr_data;
               if (load)   lim_act <= lim_pre;
            end
         end
         assign lim_sw = lim_pre;
      end else begin : g_lim_direct
         always_ff @(posedge clk) begin
            if (!rst_n)      lim_act <= '0;
            else if (wr_lim) lim_act <= wr_data;
         end
         assign lim_sw = lim_act;
      end
   endgenerate
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [CNT_W-1:0] div_act,
   output logic             tick
);
   logic [CNT_W-1:0] phase;
   logic             at_end;

   assign at_end = (phase == div_act);
   assign tick   = run && !clear && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n)      phase <= '0;
      else if (clear)  phase <= '0;
      else if (run)    phase <= at_end ? '0 : phase + 1'b1;
   end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             force_evt,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             tick,
   input  logic [CNT_W-1:0] lim_act,
   output logic [CNT_W-1:0] cnt,
   output logic             upd,
   output logic             wrap_evt
);
   assign wrap_evt = tick && !force_evt && !cnt_wr && (cnt == lim_act);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         upd <= 1'b0;
      end else if (force_evt) begin
         cnt <= '0;
         upd <= 1'b1;
      end else if (cnt_wr) begin
         cnt <= wr_data;
         upd <= 1'b0;
      end else if (wrap_evt) begin
         cnt <= '0;
         upd <= 1'b1;
      end else begin
         if (tick) cnt <= cnt + 1'b1;
         upd <= 1'b0;
      end
   end
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
   import tbase_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter bit LIM_PRELOAD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_sel,
   output logic [CNT_W-1:0] rd_data,
   input  logic             ug,
   input  logic             trig,
   output logic [CNT_W-1:0] cnt_val,
   output logic             upd
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("tbase_timer: CNT_W must lie in 2..32");
      end
   endgenerate

   logic [CNT_W-1:0] div_shadow, div_act, lim_sw, lim_act;
   logic             force_evt, load_evt, wrap_evt, run, tick, cnt_wr;

   assign force_evt = ug || trig;
   assign load_evt  = force_evt || wrap_evt;
   assign run       = en && (lim_act != '0);
   assign cnt_wr    = wr_en && (wr_sel == SEL_CNT);

   tbase_regs #(.CNT_W(CNT_W), .LIM_PRELOAD(LIM_PRELOAD)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .load(load_evt), .div_shadow(div_shadow),
      .div_act(div_act), .lim_sw(lim_sw), .lim_act(lim_act)
   );

   tbase_prescaler #(.CNT_W(CNT_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(run), .clear(force_evt),
      .div_act(div_act), .tick(tick)
   );

   tbase_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .force_evt(force_evt), .cnt_wr(cnt_wr),
      .wr_data(wr_data), .tick(tick), .lim_act(lim_act),
      .cnt(cnt_val), .upd(upd), .wrap_evt(wrap_evt)
   );

   always_comb begin
      case (rd_sel)
         SEL_CNT: rd_data = cnt_val;
         SEL_DIV: rd_data = div_shadow;
         SEL_LIM: rd_data = lim_sw;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [CNT_W-1:0] wr_data,
   input logic             ug,
   input logic             trig,
   input logic [CNT_W-1:0] cnt_val,
   input logic             upd,
   input logic [CNT_W-1:0] lim_act,
   input logic [CNT_W-1:0] div_act
);
   logic quiet;
   assign quiet = !ug && !trig && !(wr_en && wr_sel == 2'd0);

   assert_upd_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> cnt_val == '0);

   assert_step_limited_R3: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> (cnt_val == $past(cnt_val) || cnt_val == '0 ||
                 cnt_val == $past(cnt_val) + {{(CNT_W-1){1'b0}}, 1'b1}));

   assert_div_moves_on_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_act) |-> upd);

   assert_force_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ug || trig) |=> (cnt_val == '0 && upd));

   assert_zero_limit_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && lim_act == '0) |=> ($stable(cnt_val) && !upd));

   assert_cnt_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0 && !ug && !trig) |=> (cnt_val == $past(wr_data) && !upd));

   assert_disabled_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && !en) |=> ($stable(cnt_val) && !upd));
endmodule

bind tbase_timer tbase_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .ug(ug), .trig(trig), .cnt_val(cnt_val), .upd(upd),
   .lim_act(lim_act), .div_act(div_act)
);

// File: tb/tbase_timer_test.sv
`timescale 1ns/1ps
module tbase_timer_test;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0, wr_en = 1'b0, ug = 1'b0, trig = 1'b0;
   logic [1:0]   wr_sel = 2'd0, rd_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data, cnt_val;
   logic         upd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tbase_timer #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ug(ug),
      .trig(trig), .cnt_val(cnt_val), .upd(upd)
   );

   // Vector fields: {en, ug, trig, expected upd, expected counter[3:0]}
   localparam logic [7:0] VEC [0:17] = '{
      8'b1000_0001, 8'b1000_0010, 8'b1001_0000, 8'b1000_0000,
      8'b1000_0001, 8'b1000_0001, 8'b0000_0001, 8'b0000_0001,
      8'b1000_0010, 8'b1000_0010, 8'b1001_0000, 8'b1000_0000,
      8'b0101_0000, 8'b1000_0000, 8'b1000_0001, 8'b1011_0000,
      8'b1000_0000, 8'b1000_0001
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 20000);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [W-1:0] held;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 cnt", cnt_val, '0);
      chk("R1 upd", {15'd0, upd}, '0);
      for (int s = 0; s < 3; s++) begin
         rd_sel = s[1:0]; #0.1;
         chk("R1 readback", rd_data, '0);
      end

      // setup: limit 2, shadow divider 1 (active stays 0)
      wr(2'd2, 16'd2);
      wr(2'd1, 16'd1);
      rd_sel = 2'd1; #0.1; chk("R2 divider read", rd_data, 16'd1);
      rd_sel = 2'd2; #0.1; chk("R2 limit read", rd_data, 16'd2);

      // vector table: R3 R4 R5 R6 R7 R11
      for (int i = 0; i < 18; i++) begin
         en = VEC[i][7]; ug = VEC[i][6]; trig = VEC[i][5];
         step();
         ug = 1'b0; trig = 1'b0;
         chk($sformatf("R3 R4 R5 R6 R7 R11 vector %0d cnt", i), cnt_val, {12'd0, VEC[i][3:0]});
         chk($sformatf("R4 R6 R7 vector %0d upd", i), {15'd0, upd}, {15'd0, VEC[i][4]});
      end

      // R10: counter above limit rolls over with no update
      en = 1'b0;
      wr(2'd1, 16'd0);
      ug = 1'b1; step(); ug = 1'b0;
      wr(2'd2, 16'd3);
      wr(2'd0, 16'hFFFE);
      chk("R9 cnt write", cnt_val, 16'hFFFE);
      chk("R9 no update", {15'd0, upd}, '0);
      rd_sel = 2'd0; #0.1; chk("R2 counter read", rd_data, 16'hFFFE);
      en = 1'b1;
      step(); chk("R10 reach max", cnt_val, 16'hFFFF);
      step(); chk("R10 rollover", cnt_val, 16'h0000);
      chk("R10 no update", {15'd0, upd}, '0);
      step(); step(); step();
      chk("R3 count to limit", cnt_val, 16'd3);
      step();
      chk("R4 wrap cnt", cnt_val, 16'd0);
      chk("R4 wrap upd", {15'd0, upd}, 16'd1);
      step();
      chk("R4 single pulse", {15'd0, upd}, '0);

      // R8: zero limit freezes
      en = 1'b0;
      wr(2'd2, 16'd0);
      held = cnt_val;
      en = 1'b1;
      for (int k = 0; k < 4; k++) begin
         step();
         chk("R8 frozen cnt", cnt_val, held);
         chk("R8 no update", {15'd0, upd}, '0);
      end
      wr(2'd0, 16'd7);
      step();
      chk("R8 R9 write while frozen", cnt_val, 16'd7);
      trig = 1'b1; step(); trig = 1'b0;
      chk("R7 trig clears", cnt_val, 16'd0);
      chk("R7 trig upd", {15'd0, upd}, 16'd1);

      // R9 priority: ug beats counter write
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd9; ug = 1'b1;
      step();
      wr_en = 1'b0; ug = 1'b0;
      chk("R9 ug over write", cnt_val, 16'd0);

      finish_run();
   end
endmodule